// File: doc/BRIEF.md
# Command Response Capture FIFO

This block sits on the receive side of a memory-card command line. Once the host controller has sent a command, it pulses `cmdStart` with a two-bit response kind. The block then watches the sampled command-line bit, which is qualified by `bitValid`, for the response start bit. It shifts in the whole response frame and checks the short frame's CRC-7 where the kind asks for it. It then hands the captured bits to the host as a short queue of 16-bit halfwords.

A short response is unloaded as three halfwords that hold the complete 48-bit frame, most significant first. The host therefore rebuilds the 32-bit payload across a byte boundary. A long response is unloaded as eight halfwords. `respEnd` pulses once per command, at the same moment the halfwords and the error flags become valid. If no start bit arrives within a fixed number of bit strobes, the block raises a timeout instead.

Top module: `rsp_capture`

## Requirements
- R1: `respType` is sampled when `cmdStart` is high: 0 = no response, 1 = 48-bit frame with CRC check, 2 = 136-bit frame, 3 = 48-bit frame without CRC check. Kind 0 pulses `respEnd` in the cycle after `cmdStart`, with no data and both flags low.
- R2: The first `cmdBit` = 0 seen with `bitValid` high after `cmdStart` is bit 0 of the frame. Line activity before `cmdStart` has no effect.
- R3: If `TIMEOUT_BITS` valid bits, all 1, arrive before any 0, `timeoutErr` and `respEnd` are raised together and the queue stays empty. A start bit that arrives as valid bit number `TIMEOUT_BITS` or earlier is accepted.
- R4: After a 48-bit frame, three halfwords are read. Halfword k holds frame bits 16k to 16k+15, with the earlier bit in the more significant position.
- R5: For a 48-bit frame, (h0<<24)|(h1<<8)|(h2>>8), truncated to 32 bits, equals frame bits 8 to 39, the 32 bits after the start bit, the direction bit and the 6-bit index.
- R6: After a 136-bit frame, eight halfwords are read that together hold frame bits 8 to 135 in order, earliest bit first. Pairs (h0,h1) through (h6,h7) form 32-bit words with the first halfword in the upper half. `crcErr` stays low.
- R7: For kind 1, a CRC-7 with polynomial x^7+x^3+1 and zero initial value is run over frame bits 0 to 39 and compared with bits 40 to 46 (first received = most significant). A mismatch sets `crcErr`.
- R8: For kind 3, `crcErr` stays low whatever bits 40 to 46 carry.
- R9: A read strobe on an empty queue returns 0 on `rdData` and does not move the read position.
- R10: `respEnd` is a single-cycle pulse. `crcErr` and `timeoutErr` are valid from that cycle and are held until the next `cmdStart`, which clears both flags and empties the queue. After reset all outputs are 0.
- R11: `rdData` always shows the oldest unread halfword. It advances only on a `rdStrobe` cycle.
- R12: `cmdBit` is ignored in every cycle where `bitValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Command sent; arm the capture and sample `respType` |
| respType | input | 2 | Expected response kind |
| bitValid | input | 1 | Strobe qualifying `cmdBit` |
| cmdBit | input | 1 | Sampled command-line level |
| rdStrobe | input | 1 | Host consumes the halfword shown on `rdData` |
| rdData | output | 16 | Oldest unread halfword, 0 when empty |
| respEnd | output | 1 | One-cycle end-of-response event |
| crcErr | output | 1 | Short-frame CRC mismatch |
| timeoutErr | output | 1 | No start bit within the timeout window |

## Verification
The bench targets the timeout edge, where a start bit on the last allowed strobe must still be accepted: a counter that is off by one would report a timeout there, or accept a start bit one strobe late. It corrupts the CRC field on both short kinds, because a design that checked CRC by frame length instead of by kind would flag kind 3 responses. Zeros are driven with `bitValid` low during the start-bit hunt, and the line is toggled before `cmdStart`, to catch a design that takes an unqualified or stale bit as the start bit. Reads past the end of the queue must return zero, and `rdData` must not change without a read; a pointer that wraps would show old halfwords again.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int HALF_W       = 16;
  localparam int SHORT_BITS   = 48;
  localparam int LONG_BITS    = 136;
  localparam int LONG_KEEP    = 128;
  localparam int CRC_SPAN     = 40;
  localparam int CRC_W        = 7;
  localparam int SHORT_HALVES = SHORT_BITS / HALF_W;
  localparam int LONG_HALVES  = LONG_KEEP / HALF_W;
  localparam int CNT_W        = $clog2(LONG_BITS + 1);
  localparam int FILL_W       = $clog2(LONG_HALVES + 1);
  localparam int IDX_W        = $clog2(LONG_HALVES);
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'd0,
    RSP_SHORT_CRC = 2'd1,
    RSP_LONG      = 2'd2,
    RSP_SHORT_RAW = 2'd3
  } rspKind_e;

  typedef struct packed {
    logic clear;
    logic shift;
    logic crcUpd;
    logic load;
    logic longSel;
    logic checkCrc;
  } rspStrb_t;
endpackage

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_pkg::*;
#(
  parameter int TIMEOUT_BITS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [1:0] respType,
  input  logic       bitValid,
  input  logic       cmdBit,
  output rspStrb_t   strb,
  output logic       respEnd,
  output logic       timeoutErr
);
  localparam int TO_W = $clog2(TIMEOUT_BITS + 1);
  localparam logic [TO_W-1:0]  TO_LAST    = TO_W'(TIMEOUT_BITS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] CRC_END    = CNT_W'(CRC_SPAN);

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_RECV, ST_LOAD} state_e;

  state_e           state;
  rspKind_e         kindQ;
  logic [CNT_W-1:0] bitCnt;
  logic [TO_W-1:0]  toCnt;
  logic             respEndQ;
  logic             timeoutQ;

  logic             startSeen;
  logic             huntExpire;
  logic             rxBit;
  logic [CNT_W-1:0] frameLast;

  always_comb begin
    frameLast  = (kindQ == RSP_LONG) ? LONG_LAST : SHORT_LAST;
    startSeen  = (state == ST_HUNT) && bitValid && !cmdBit;
    huntExpire = (state == ST_HUNT) && bitValid && cmdBit && (toCnt == TO_LAST);
    rxBit      = (state == ST_RECV) && bitValid;

    strb.clear    = cmdStart;
    strb.shift    = !cmdStart && (startSeen || rxBit);
    strb.crcUpd   = !cmdStart && (startSeen || (rxBit && (bitCnt < CRC_END)));
    strb.load     = !cmdStart && (state == ST_LOAD);
    strb.longSel  = (kindQ == RSP_LONG);
    strb.checkCrc = (kindQ == RSP_SHORT_CRC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kindQ    <= RSP_NONE;
      bitCnt   <= '0;
      toCnt    <= '0;
      respEndQ <= 1'b0;
      timeoutQ <= 1'b0;
    end else if (cmdStart) begin
      kindQ    <= rspKind_e'(respType);
      bitCnt   <= '0;
      toCnt    <= '0;
      timeoutQ <= 1'b0;
      respEndQ <= (respType == RSP_NONE);
      state    <= (respType == RSP_NONE) ? ST_IDLE : ST_HUNT;
    end else begin
      respEndQ <= 1'b0;
      case (state)
        ST_HUNT: begin
          if (startSeen) begin
            bitCnt <= CNT_W'(1);
            state  <= ST_RECV;
          end else if (huntExpire) begin
            timeoutQ <= 1'b1;
            respEndQ <= 1'b1;
            state    <= ST_IDLE;
          end else if (bitValid) begin
            toCnt <= toCnt + TO_W'(1);
          end
        end
        ST_RECV: begin
          if (bitValid) begin
            if (bitCnt == frameLast) state <= ST_LOAD;
            else                     bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_LOAD: begin
          respEndQ <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign respEnd    = respEndQ;
  assign timeoutErr = timeoutQ;
endmodule

// File: rtl/rsp_dpath.sv
module rsp_dpath
  import rsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rspStrb_t          strb,
  input  logic              cmdBit,
  input  logic              rdStrobe,
  output logic [HALF_W-1:0] rdData,
  output logic              crcErr
);
  logic [LONG_KEEP-1:0] shiftQ;
  logic [CRC_W-1:0]     crcQ;
  logic [HALF_W-1:0]    mem [LONG_HALVES];
  logic [FILL_W-1:0]    fillQ;
  logic [FILL_W-1:0]    rdPtr;
  logic                 crcErrQ;

  logic [HALF_W-1:0]    slotLong  [LONG_HALVES];
  logic [HALF_W-1:0]    slotShort [LONG_HALVES];
  logic                 empty;
  logic                 crcFb;

  for (genvar i = 0; i < LONG_HALVES; i++) begin : g_slot
    assign slotLong[i] = shiftQ[LONG_KEEP-1-HALF_W*i -: HALF_W];
    if (i < SHORT_HALVES) begin : g_short
      assign slotShort[i] = shiftQ[SHORT_BITS-1-HALF_W*i -: HALF_W];
    end else begin : g_pad
      assign slotShort[i] = '0;
    end
  end

  assign crcFb = crcQ[CRC_W-1] ^ cmdBit;
  assign empty = (rdPtr == fillQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      crcQ   <= '0;
    end else if (strb.clear) begin
      shiftQ <= '0;
      crcQ   <= '0;
    end else begin
      if (strb.shift)
        shiftQ <= {shiftQ[LONG_KEEP-2:0], cmdBit};
      if (strb.crcUpd)
        crcQ <= {crcQ[CRC_W-2:0], 1'b0} ^ (crcFb ? CRC_POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LONG_HALVES; i++) mem[i] <= '0;
    end else if (strb.load) begin
      for (int i = 0; i < LONG_HALVES; i++)
        mem[i] <= strb.longSel ? slotLong[i] : slotShort[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillQ   <= '0;
      rdPtr   <= '0;
      crcErrQ <= 1'b0;
    end else if (strb.clear) begin
      fillQ   <= '0;
      rdPtr   <= '0;
      crcErrQ <= 1'b0;
    end else if (strb.load) begin
      fillQ   <= strb.longSel ? FILL_W'(LONG_HALVES) : FILL_W'(SHORT_HALVES);
      rdPtr   <= '0;
      crcErrQ <= strb.checkCrc && (crcQ != shiftQ[CRC_W:1]);
    end else if (rdStrobe && !empty) begin
      rdPtr <= rdPtr + FILL_W'(1);
    end
  end

  assign rdData = empty ? '0 : mem[rdPtr[IDX_W-1:0]];
  assign crcErr = crcErrQ;
endmodule

// File: rtl/rsp_capture.sv
module rsp_capture
  import rsp_pkg::*;
#(
  parameter int TIMEOUT_BITS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic [1:0]  respType,
  input  logic        bitValid,
  input  logic        cmdBit,
  input  logic        rdStrobe,
  output logic [15:0] rdData,
  output logic        respEnd,
  output logic        crcErr,
  output logic        timeoutErr
);
  rspStrb_t strb;

  rsp_ctrl #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .respType   (respType),
    .bitValid   (bitValid),
    .cmdBit     (cmdBit),
    .strb       (strb),
    .respEnd    (respEnd),
    .timeoutErr (timeoutErr)
  );

  rsp_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdBit   (cmdBit),
    .rdStrobe (rdStrobe),
    .rdData   (rdData),
    .crcErr   (crcErr)
  );
endmodule

// File: rtl/rsp_capture_chk.sv
module rsp_capture_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdStart,
  input logic [1:0]  respType,
  input logic        bitValid,
  input logic        cmdBit,
  input logic        rdStrobe,
  input logic [15:0] rdData,
  input logic        respEnd,
  input logic        crcErr,
  input logic        timeoutErr
);
  p_end_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    (respEnd && !cmdStart) |=> !respEnd);

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(crcErr && timeoutErr));

  p_crc_with_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErr) |-> respEnd);

  p_timeout_with_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> respEnd);

  p_timeout_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (rdData == 16'h0000));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> (!crcErr && !timeoutErr));

  p_head_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!respEnd && !$past(rdStrobe) && !$past(cmdStart)) |-> $stable(rdData));
endmodule

bind rsp_capture rsp_capture_chk u_chk (.*);

// File: tb/sim_rsp_capture.sv
module sim_rsp_capture;
  localparam int TO_BITS = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [1:0]  respType = 2'd0;
  logic        bitValid = 1'b0;
  logic        cmdBit = 1'b1;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;
  logic        respEnd;
  logic        crcErr;
  logic        timeoutErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rsp_capture #(.TIMEOUT_BITS(TO_BITS)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .respType(respType),
    .bitValid(bitValid), .cmdBit(cmdBit), .rdStrobe(rdStrobe),
    .rdData(rdData), .respEnd(respEnd), .crcErr(crcErr), .timeoutErr(timeoutErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [47:0] f);
    logic [6:0] c = '0;
    for (int i = 47; i >= 8; i--) begin
      logic fb = c[6] ^ f[i];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] mkShort(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [47:0] f;
    f[47] = 1'b0; f[46] = 1'b0; f[45:40] = idx; f[39:8] = arg; f[7:0] = '0;
    f[7:1] = crc7(f) ^ (bad ? 7'h05 : 7'h00);
    f[0] = 1'b1;
    return f;
  endfunction

  task automatic startCmd(input logic [1:0] t);
    @(negedge clk); cmdStart = 1'b1; respType = t;
    @(negedge clk); cmdStart = 1'b0;
  endtask

  task automatic sendBit(input logic b, input int gap);
    bitValid = 1'b1; cmdBit = b;
    @(negedge clk);
    bitValid = 1'b0; cmdBit = $urandom % 2;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [135:0] f, input int len, input int pre);
    for (int i = 0; i < pre; i++) sendBit(1'b1, $urandom % 2);
    for (int i = len - 1; i >= 0; i--) sendBit(f[i], (i == 0) ? 0 : ($urandom % 3));
  endtask

  task automatic waitEnd(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (respEnd) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic readHalf(output logic [15:0] h);
    h = rdData; rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic runShort(input logic [1:0] t, input bit bad, input int pre);
    logic [5:0] idx = 6'($urandom);
    logic [31:0] arg = $urandom;
    logic [47:0] f = mkShort(idx, arg, bad);
    logic [15:0] h [3];
    logic [31:0] pay;
    bit seen;
    startCmd(t);
    sendFrame({88'h0, f}, 48, pre);
    waitEnd(seen);
    check(seen, "R10 end pulse short", 64'(seen), 64'd1);
    @(negedge clk);
    check(crcErr == (bad && t == 2'd1), (t == 2'd1) ? "R7 crc flag" : "R8 no crc check",
          64'(crcErr), 64'(bad && t == 2'd1));
    for (int k = 0; k < 3; k++) readHalf(h[k]);
    check({h[0], h[1], h[2]} == f, "R4 short halfwords", {16'h0, h[0], h[1], h[2]}, {16'h0, f});
    pay = 32'((h[0] << 24) | (h[1] << 8) | (h[2] >> 8));
    check(pay == arg, "R5 payload reassembly", 64'(pay), 64'(arg));
  endtask

  task automatic runLong(input int pre);
    logic [127:0] pl = {$urandom, $urandom, $urandom, $urandom};
    logic [135:0] f = {2'b00, 6'h3f, pl};
    logic [127:0] got;
    logic [15:0] h;
    bit seen;
    startCmd(2'd2);
    sendFrame(f, 136, pre);
    waitEnd(seen);
    check(seen, "R10 end pulse long", 64'(seen), 64'd1);
    @(negedge clk);
    check(!crcErr, "R6 long no crc", 64'(crcErr), 64'd0);
    for (int k = 0; k < 8; k++) begin readHalf(h); got = {got[111:0], h}; end
    check(got[127:64] == pl[127:64], "R6 long upper", got[127:64], pl[127:64]);
    check(got[63:0] == pl[63:0], "R6 long lower", got[63:0], pl[63:0]);
  endtask

  initial begin : main
    logic [15:0] h;
    logic [15:0] h2;
    bit seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 0 && !respEnd && !crcErr && !timeoutErr, "R10 reset state",
          {rdData, respEnd, crcErr, timeoutErr}, 64'd0);

    // R2: line activity with no command armed
    for (int i = 0; i < 60; i++) sendBit(1'($urandom), 0);
    check(!respEnd && rdData == 0, "R2 idle bits ignored", {rdData, respEnd}, 64'd0);

    // R1: no-response kind
    @(negedge clk); cmdStart = 1'b1; respType = 2'd0;
    @(negedge clk); cmdStart = 1'b0;
    check(respEnd && !crcErr && !timeoutErr && rdData == 0, "R1 none kind end",
          {rdData, respEnd, crcErr, timeoutErr}, 64'h4);
    @(negedge clk);
    check(!respEnd, "R10 single pulse", 64'(respEnd), 64'd0);

    // R12: zeros without bitValid during hunt
    startCmd(2'd1);
    for (int i = 0; i < 10; i++) begin cmdBit = 1'b0; @(negedge clk); end
    check(!respEnd, "R12 unqualified zeros", 64'(respEnd), 64'd0);
    begin
      logic [47:0] f = mkShort(6'h11, 32'hcafe_1234, 1'b0);
      logic [15:0] hh [3];
      sendFrame({88'h0, f}, 48, 2);
      waitEnd(seen);
      @(negedge clk);
      for (int k = 0; k < 3; k++) readHalf(hh[k]);
      check({hh[0], hh[1], hh[2]} == f, "R12 frame intact", {16'h0, hh[0], hh[1], hh[2]}, {16'h0, f});
    end

    // R9 / R11: empty reads and head stability
    readHalf(h);
    readHalf(h2);
    check(h == 0 && h2 == 0, "R9 empty read zero", {h, h2}, 64'd0);

    runShort(2'd1, 1'b0, 5);
    runShort(2'd1, 1'b1, 0);
    runShort(2'd3, 1'b1, 3);
    runShort(2'd3, 1'b0, 1);
    runLong(4);

    // R11: head holds without a read
    runShort(2'd3, 1'b0, 0);
    startCmd(2'd1);
    sendFrame({88'h0, mkShort(6'h2a, 32'h0123_4567, 1'b0)}, 48, 0);
    waitEnd(seen);
    @(negedge clk);
    h = rdData;
    repeat (3) @(negedge clk);
    check(rdData == h && h == 16'h2a01, "R11 head stable", {rdData, h}, {16'h2a01, 16'h2a01});
    readHalf(h);
    check(rdData == 16'h2345, "R11 advance on read", 64'(rdData), 64'h2345);

    // R10: new command clears flags and queue
    startCmd(2'd1);
    sendFrame({88'h0, mkShort(6'h01, 32'h5, 1'b1)}, 48, 0);
    waitEnd(seen);
    @(negedge clk);
    check(crcErr, "R7 directed mismatch", 64'(crcErr), 64'd1);
    startCmd(2'd3);
    check(!crcErr && rdData == 0, "R10 start clears", {rdData, crcErr}, 64'd0);

    // R3: timeout after TO_BITS ones
    for (int i = 0; i < TO_BITS; i++) sendBit(1'b1, 0);
    waitEnd(seen);
    check(seen && timeoutErr, "R3 timeout raised", {seen, timeoutErr}, 64'h3);
    check(rdData == 0, "R3 timeout empty", 64'(rdData), 64'd0);

    // R3: start bit on last allowed strobe is accepted
    runShort(2'd1, 1'b0, TO_BITS - 1);
    check(!timeoutErr, "R3 late start accepted", 64'(timeoutErr), 64'd0);

    for (int n = 0; n < 30; n++) begin
      int kind = $urandom % 3;
      if (kind == 2) runLong($urandom % 8);
      else runShort(kind == 0 ? 2'd1 : 2'd3, ($urandom % 4) == 0, $urandom % 8);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule